// File: doc/BRIEF.md
# Ranked Output-Direction Selector for a Mesh Router

This block sits in each router of a two-dimensional mesh and decides which neighbour receives a wormhole packet. It holds a table with one entry per destination node. Each entry ranks up to four output directions. When a header flit arrives, the selector looks up the entry for the header's destination. It walks down the ranking and skips every direction whose neighbouring input buffer reports full. It grants the first direction that remains, in the same cycle. If no direction can be granted, the header is refused, and the choice is made again in every following cycle until one becomes free.

A per-packet bit in the header keeps the choice to directions that bring the packet closer to its destination. A destination whose entry lists no valid direction falls back to plain minimal routing, with the vertical dimension tried first. After a grant, the chosen direction is held for the body flits until the tail flit leaves. Two write ports fill the table: one for the local processing element and one for configuration packets.

Top module: `route_pref_sel`

## Requirements
- R1: For an idle selector, a header flit whose table entry has valid slots is granted the valid direction of lowest slot index (slot 0 = first choice) whose neighbour is not full. `out_valid`, `in_ready` and `out_dir` respond in the same cycle as the header.
- R2: A slot whose direction has its `nbr_full` bit set is skipped, and the next valid slot is tried.
- R3: If no direction qualifies, `in_ready` and `out_valid` stay low. The selection is made again every cycle and grants in the first cycle in which a qualifying neighbour frees.
- R4: With `in_min_only` high, a direction qualifies only if it is minimal. North is minimal when dst_y > cur_y, South when dst_y < cur_y, East when dst_x > cur_x and West when dst_x < cur_x.
- R5: A slot whose valid bit is clear is never granted, whatever direction it holds.
- R6: If an entry has no valid slot, the selector grants a minimal direction whose neighbour is not full. North or South is tried before East or West.
- R7: After a non-tail header is granted, every later flit goes to the same direction. A flit passes only in a cycle where that neighbour is not full. After the tail flit passes, the next header is selected afresh.
- R8: Direction codes are North=0, East=1, South=2 and West=3. Bit d of `nbr_full` is the full flag of direction d. In the ranks word, slot k occupies bits [2k+1:2k]. Valid bit k belongs to slot k. A destination (x,y) uses table row y*MESH_X+x.
- R9: When a table row is written in the same cycle as a lookup of that row, the lookup sees the old contents. The new contents are seen from the next cycle.
- R10: When both write ports target the same row in one cycle, the processing-element port wins. When they target different rows, both writes land.
- R11: Reset (synchronous, active high) clears every valid bit and returns the selector to idle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_x | input | XW | Column of this router |
| cur_y | input | YW | Row of this router |
| in_valid | input | 1 | A flit is present at the input |
| in_head | input | 1 | Flit is a header |
| in_tail | input | 1 | Flit is the last of its packet |
| in_min_only | input | 1 | Header bit: only minimal directions allowed |
| in_dst_x | input | XW | Destination column from the header |
| in_dst_y | input | YW | Destination row from the header |
| nbr_full | input | 4 | Full flags of neighbour input buffers, indexed by direction code |
| pe_we | input | 1 | Processing-element table write enable |
| pe_addr | input | AW | Processing-element write row |
| pe_ranks | input | 8 | Four 2-bit ranked directions |
| pe_vld | input | 4 | Valid bit per slot |
| pk_we | input | 1 | Configuration-packet table write enable |
| pk_addr | input | AW | Configuration-packet write row |
| pk_ranks | input | 8 | Four 2-bit ranked directions |
| pk_vld | input | 4 | Valid bit per slot |
| in_ready | output | 1 | Flit taken this cycle when in_valid is high |
| out_valid | output | 1 | Flit forwarded this cycle |
| out_dir | output | 2 | Direction the flit is forwarded to |

## Verification
The assertions watch these properties on every cycle:
- no grant ever targets a full neighbour;
- a header with every neighbour full is refused;
- a grant made under the minimal-only bit is in fact minimal;
- successive flits of one packet keep the same direction;
- a processing-element write lands in its row.

Some behaviours depend on table contents and on order in time, so only the bench's scenarios can show them:
- the exact fall-through order across ranks;
- skipped invalid slots;
- the vertical-first fallback for empty entries;
- read-before-write on a shared row;
- which port wins a same-row write.

The bench checks these against a shadow table and a reference selection function.

// File: rtl/rps_pkg.sv
package rps_pkg;

    localparam int NUM_RANKS = 4;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef struct packed {
        logic [NUM_RANKS-1:0]       vld;
        logic [NUM_RANKS-1:0][1:0]  dir;
    } rank_entry_t;

    function automatic rank_entry_t make_entry(input logic [7:0] ranks, input logic [3:0] vld);
        rank_entry_t e;
        e.vld = vld;
        for (int k = 0; k < NUM_RANKS; k++) begin
            e.dir[k] = ranks[2*k +: 2];
        end
        return e;
    endfunction

endpackage

// File: rtl/rps_table.sv
module rps_table
    import rps_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pe_we,
    input  logic [AW-1:0] pe_addr,
    input  rank_entry_t pe_ent,
    input  logic        pk_we,
    input  logic [AW-1:0] pk_addr,
    input  rank_entry_t pk_ent,
    input  logic [AW-1:0] rd_addr,
    output rank_entry_t rd_ent
);

    rank_entry_t tbl_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            if (pk_we) tbl_q[pk_addr] <= pk_ent;
            if (pe_we) tbl_q[pe_addr] <= pe_ent;
        end
    end

    assign rd_ent = tbl_q[rd_addr];

    a_r10_pe_lands: assert property (@(posedge clk) disable iff (rst)
        pe_we |=> (tbl_q[$past(pe_addr)] == $past(pe_ent)));

endmodule

// File: rtl/rps_pick.sv
module rps_pick
    import rps_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  rank_entry_t   ent,
    input  logic [3:0]    nbr_full,
    input  logic          min_only,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic          have,
    output dir_e          dir
);

    logic [3:0] minm;
    logic [3:0] allow;
    logic [3:0] fb_ok;
    logic [NUM_RANKS-1:0] rank_ok;

    always_comb begin
        minm        = '0;
        minm[DIR_N] = dst_y > cur_y;
        minm[DIR_E] = dst_x > cur_x;
        minm[DIR_S] = dst_y < cur_y;
        minm[DIR_W] = dst_x < cur_x;
    end

    assign allow = ~nbr_full & (min_only ? minm : 4'hF);
    assign fb_ok = ~nbr_full & minm;

    for (genvar k = 0; k < NUM_RANKS; k++) begin : g_rank
        assign rank_ok[k] = ent.vld[k] && allow[ent.dir[k]];
    end

    always_comb begin
        have = 1'b0;
        dir  = DIR_N;
        if (|ent.vld) begin
            for (int k = NUM_RANKS - 1; k >= 0; k--) begin
                if (rank_ok[k]) begin
                    have = 1'b1;
                    dir  = dir_e'(ent.dir[k]);
                end
            end
        end else if (fb_ok[DIR_N]) begin
            have = 1'b1; dir = DIR_N;
        end else if (fb_ok[DIR_S]) begin
            have = 1'b1; dir = DIR_S;
        end else if (fb_ok[DIR_E]) begin
            have = 1'b1; dir = DIR_E;
        end else if (fb_ok[DIR_W]) begin
            have = 1'b1; dir = DIR_W;
        end
    end

endmodule

// File: rtl/rps_hold.sv
module rps_hold
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hdr_take,
    input  logic tail_take,
    input  dir_e grant_dir,
    output logic busy,
    output dir_e held_dir
);

    logic busy_q;
    dir_e held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            held_q <= DIR_N;
        end else if (hdr_take) begin
            busy_q <= 1'b1;
            held_q <= grant_dir;
        end else if (tail_take) begin
            busy_q <= 1'b0;
        end
    end

    assign busy     = busy_q;
    assign held_dir = held_q;

    a_r7_tail_frees: assert property (@(posedge clk) disable iff (rst)
        tail_take |=> !busy_q);

endmodule

// File: rtl/route_pref_sel.sv
module route_pref_sel
    import rps_pkg::*;
#(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8,
    parameter int XW     = $clog2(MESH_X),
    parameter int YW     = $clog2(MESH_Y),
    parameter int DEPTH  = MESH_X * MESH_Y,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          in_valid,
    input  logic          in_head,
    input  logic          in_tail,
    input  logic          in_min_only,
    input  logic [XW-1:0] in_dst_x,
    input  logic [YW-1:0] in_dst_y,
    input  logic [3:0]    nbr_full,
    input  logic          pe_we,
    input  logic [AW-1:0] pe_addr,
    input  logic [7:0]    pe_ranks,
    input  logic [3:0]    pe_vld,
    input  logic          pk_we,
    input  logic [AW-1:0] pk_addr,
    input  logic [7:0]    pk_ranks,
    input  logic [3:0]    pk_vld,
    output logic          in_ready,
    output logic          out_valid,
    output logic [1:0]    out_dir
);

    rank_entry_t   rd_ent;
    logic [AW-1:0] rd_addr;
    logic          have;
    dir_e          pick_dir;
    logic          busy;
    dir_e          held_dir;
    dir_e          sel_dir;
    logic          ready_c;
    logic          hdr_take;
    logic          tail_take;

    assign rd_addr = AW'(32'(in_dst_y) * MESH_X + 32'(in_dst_x));

    rps_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk     (clk),
        .rst     (rst),
        .pe_we   (pe_we),
        .pe_addr (pe_addr),
        .pe_ent  (make_entry(pe_ranks, pe_vld)),
        .pk_we   (pk_we),
        .pk_addr (pk_addr),
        .pk_ent  (make_entry(pk_ranks, pk_vld)),
        .rd_addr (rd_addr),
        .rd_ent  (rd_ent)
    );

    rps_pick #(.XW(XW), .YW(YW)) u_pick (
        .ent      (rd_ent),
        .nbr_full (nbr_full),
        .min_only (in_min_only),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .dst_x    (in_dst_x),
        .dst_y    (in_dst_y),
        .have     (have),
        .dir      (pick_dir)
    );

    always_comb begin
        if (!busy) begin
            ready_c = in_head && have;
            sel_dir = pick_dir;
        end else begin
            ready_c = !nbr_full[held_dir];
            sel_dir = held_dir;
        end
    end

    assign in_ready  = ready_c;
    assign out_valid = in_valid && ready_c;
    assign out_dir   = sel_dir;
    assign hdr_take  = !busy && out_valid && !in_tail;
    assign tail_take = busy && out_valid && in_tail;

    rps_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .hdr_take  (hdr_take),
        .tail_take (tail_take),
        .grant_dir (pick_dir),
        .busy      (busy),
        .held_dir  (held_dir)
    );

    a_r2_free_target: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !nbr_full[out_dir]);

    a_r3_all_full_wait: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid && in_head && (&nbr_full)) |-> !in_ready);

    a_r4_minimal_only: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !busy && in_min_only) |->
            ((out_dir == 2'd0 && in_dst_y > cur_y) || (out_dir == 2'd1 && in_dst_x > cur_x) ||
             (out_dir == 2'd2 && in_dst_y < cur_y) || (out_dir == 2'd3 && in_dst_x < cur_x)));

    a_r7_same_dir: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !in_tail) |=> (!out_valid || $stable(out_dir)));

endmodule

// File: tb/route_pref_sel_tb.sv
module route_pref_sel_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cur_x, cur_y, in_dst_x, in_dst_y;
    logic       in_valid, in_head, in_tail, in_min_only;
    logic [3:0] nbr_full;
    logic       pe_we, pk_we;
    logic [5:0] pe_addr, pk_addr;
    logic [7:0] pe_ranks, pk_ranks;
    logic [3:0] pe_vld, pk_vld;
    logic       in_ready, out_valid;
    logic [1:0] out_dir;

    int total = 0;
    int bad   = 0;
    logic [11:0] sh [64];

    always #4 clk = ~clk;

    route_pref_sel u_dut (
        .clk(clk), .rst(rst), .cur_x(cur_x), .cur_y(cur_y),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_min_only(in_min_only), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
        .nbr_full(nbr_full),
        .pe_we(pe_we), .pe_addr(pe_addr), .pe_ranks(pe_ranks), .pe_vld(pe_vld),
        .pk_we(pk_we), .pk_addr(pk_addr), .pk_ranks(pk_ranks), .pk_vld(pk_vld),
        .in_ready(in_ready), .out_valid(out_valid), .out_dir(out_dir)
    );

    // reference selection: {granted, dir}
    function automatic logic [2:0] ref_sel(input logic [11:0] e, input logic [3:0] full,
                                           input logic mn, input logic [2:0] cx, cy, dx, dy);
        logic [3:0] mm;
        logic [1:0] d;
        mm = {dx < cx, dy < cy, dx > cx, dy > cy};
        if (e[11:8] != 4'h0) begin
            for (int k = 0; k < 4; k++) begin
                d = e[2*k +: 2];
                if (e[8+k] && !full[d] && (!mn || mm[d])) return {1'b1, d};
            end
            return 3'b000;
        end
        if (mm[0] && !full[0]) return 3'b100;
        if (mm[2] && !full[2]) return 3'b110;
        if (mm[1] && !full[1]) return 3'b101;
        if (mm[3] && !full[3]) return 3'b111;
        return 3'b000;
    endfunction

    task automatic check_sel(input string tag, input logic [2:0] exp);
        total++;
        if (out_valid !== exp[2] || in_ready !== exp[2] || (exp[2] && out_dir !== exp[1:0])) begin
            bad++;
            $display("FAIL %s: got valid=%0b ready=%0b dir=%0d, expected valid=%0b dir=%0d",
                     tag, out_valid, in_ready, out_dir, exp[2], exp[1:0]);
        end
    endtask

    task automatic hdr(input logic [2:0] dx, dy, input logic mn, input logic hd, tl,
                       input logic [3:0] full);
        in_valid = 1'b1; in_head = hd; in_tail = tl; in_min_only = mn;
        in_dst_x = dx; in_dst_y = dy; nbr_full = full;
    endtask

    task automatic pe_wr(input logic [5:0] a, input logic [7:0] r, input logic [3:0] v);
        pe_we = 1'b1; pe_addr = a; pe_ranks = r; pe_vld = v;
    endtask

    task automatic pk_wr(input logic [5:0] a, input logic [7:0] r, input logic [3:0] v);
        pk_we = 1'b1; pk_addr = a; pk_ranks = r; pk_vld = v;
    endtask

    // after checks: mirror writes, cross the edge, back to idle drive
    task automatic tick();
        if (pk_we) sh[pk_addr] = {pk_vld, pk_ranks};
        if (pe_we) sh[pe_addr] = {pe_vld, pe_ranks};
        @(posedge clk);
        @(negedge clk);
        pe_we = 1'b0; pk_we = 1'b0; in_valid = 1'b0; in_head = 1'b0; in_tail = 1'b0;
        in_min_only = 1'b0; nbr_full = 4'h0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] e;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) sh[i] = 12'h0;
        rst = 1'b1; cur_x = 3'd3; cur_y = 3'd3;
        in_valid = 0; in_head = 0; in_tail = 0; in_min_only = 0;
        in_dst_x = 0; in_dst_y = 0; nbr_full = 0;
        pe_we = 0; pk_we = 0; pe_addr = 0; pk_addr = 0;
        pe_ranks = 0; pk_ranks = 0; pe_vld = 0; pk_vld = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2 check_sel("R11 idle after reset", 3'b000);
        tick();

        // empty table: vertical-first minimal fallback, dst (5,6) = row 53
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R11 R6 cleared entry goes north", 3'b100); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0001); #2 check_sel("R6 north full goes east", 3'b101); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0011); #2 check_sel("R6 no minimal free stalls", 3'b000); tick();

        // ranks W,S,E,N all valid (R8 layout: slot0 in bits 1:0)
        pe_wr(6'd53, 8'h1B, 4'hF); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R1 R8 first rank west", 3'b111); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b1000); #2 check_sel("R2 west full falls to south", 3'b110); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b1111); #2 check_sel("R3 all full stalls", 3'b000); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b1111); #2 check_sel("R3 still stalled", 3'b000); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b1101); #2 check_sel("R3 retry grants east", 3'b101); tick();
        hdr(3'd5, 3'd6, 1, 1, 1, 4'b0000); #2 check_sel("R4 min only skips west south", 3'b101); tick();

        pe_wr(6'd53, 8'h1B, 4'b1100); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R5 invalid slots skipped", 3'b101); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0010); #2 check_sel("R5 last slot north", 3'b100); tick();

        // multi-flit packet
        pe_wr(6'd53, 8'h1B, 4'hF); tick();
        hdr(3'd5, 3'd6, 0, 1, 0, 4'b0000); #2 check_sel("R7 header west", 3'b111); tick();
        hdr(3'd5, 3'd6, 0, 0, 0, 4'b0111); #2 check_sel("R7 body keeps west", 3'b111); tick();
        hdr(3'd5, 3'd6, 0, 0, 0, 4'b1000); #2 check_sel("R7 body waits on west", 3'b000); tick();
        hdr(3'd5, 3'd6, 0, 0, 1, 4'b0000); #2 check_sel("R7 tail west", 3'b111); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b1000); #2 check_sel("R7 next header reselects", 3'b110); tick();

        // read during write of same row
        pe_wr(6'd53, 8'h00, 4'b0001);
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R9 old contents seen", 3'b111); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R9 new contents next cycle", 3'b100); tick();

        // dual port writes
        pe_wr(6'd53, 8'h02, 4'b0001); pk_wr(6'd53, 8'h01, 4'b0001); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R10 pe wins same row", 3'b110); tick();
        pe_wr(6'd53, 8'h01, 4'b0001); pk_wr(6'd54, 8'h03, 4'b0001); tick();
        hdr(3'd5, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R10 pe row lands", 3'b101); tick();
        hdr(3'd6, 3'd6, 0, 1, 1, 4'b0000); #2 check_sel("R10 packet row lands", 3'b111); tick();

        // random mix
        for (int it = 0; it < 400; it++) begin
            cur_x = 3'($urandom); cur_y = 3'($urandom);
            if ($urandom % 3 == 0) pe_wr(6'($urandom), 8'($urandom), 4'($urandom));
            if ($urandom % 3 == 0) pk_wr(6'($urandom), 8'($urandom), 4'($urandom));
            hdr(3'($urandom), 3'($urandom), 1'($urandom), 1, 1, 4'($urandom));
            e = ref_sel(sh[{in_dst_y, in_dst_x}], nbr_full, in_min_only,
                        cur_x, cur_y, in_dst_x, in_dst_y);
            #2 check_sel("R1 R2 R4 R5 R6 random header", e);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule